// File: doc/BRIEF.md
# CAN Receive Double Buffer with Acceptance Gate

This block holds received CAN frames between the frame receiver and the processor. A receiver front end offers one complete frame per cycle with `in_valid`: an identifier, an extended-format flag, a length code and up to eight payload bytes. Alongside each frame, an external acceptance filter supplies a pass/fail verdict and the index of the identifier group that matched. Only frames that pass are stored, in a two-entry first-in first-out buffer. The oldest frame is always visible on the `rd_*` outputs. The processor frees it with a release command, and at that moment the second frame moves to the front.

An accepted frame that arrives while both entries are occupied is a data overrun. That frame is thrown away, both stored frames stay untouched, and a sticky overrun flag is set. The flag is cleared by its own command. A frame the filter rejects never changes any state, even when the buffer is full, so the receive path can never be wedged by a rejected frame.

A soft reset command empties the buffer and clears the overrun condition without a full block reset. Two interrupt outputs are provided: a receive pulse when the buffer leaves the empty state, and an overrun level.

Top module: `can_rx_dbuf`

## Requirements
- R1: Accepted frames (`in_valid`=1 and `flt_accept`=1) are held in arrival order. The oldest frame is presented on `rd_id`, `rd_ext`, `rd_dlc`, `rd_data` and `rd_group` from the cycle after it is stored. `rd_count` gives the number of held frames (0 to 2), and `rd_valid` is 1 exactly when `rd_count` is non-zero.
- R2: `cmd_release` drops the oldest frame, and the second frame is at the front in the next cycle. A release while the buffer is empty has no effect.
- R3: An accepted frame that arrives while two frames are held, with no release in the same cycle, is discarded. The two held frames stay unchanged and `ovr_status` reads 1 from the next cycle.
- R4: A frame with `flt_accept`=0 is never stored. It leaves `rd_count`, the held frames and `ovr_status` unchanged, whether or not the buffer is full, and later accepted frames are stored normally.
- R5: Each stored frame keeps the `flt_group` value that arrived with it, and shows it on `rd_group`.
- R6: When an accepted frame and `cmd_release` arrive in the same cycle with the buffer full, the release is applied first. The new frame becomes the second entry and no overrun is flagged.
- R7: `ovr_irq` equals `ovr_status` AND `ovr_irq_en`.
- R8: `cmd_clr_ovr` clears `ovr_status` in the next cycle. If a new overrun occurs in the same cycle, the overrun wins and the flag stays 1.
- R9: `rx_irq` is a one-cycle pulse, in the cycle after a frame is stored into an empty buffer, provided `rx_irq_en` is 1.
- R10: `soft_rst` empties the buffer, clears `ovr_status` and `rx_irq`, and overrides any frame, release or clear in the same cycle.
- R11: Payload byte k is `in_data[8k+7:8k]`. Bytes at positions at or beyond min(`in_dlc`, 8) are stored as zero. Length codes 9 to 15 are stored unchanged and keep all eight bytes.
- R12: After `rst` (synchronous, active high), `rd_count`=0, `rd_valid`=0, `ovr_status`=0, `rx_irq`=0 and `ovr_irq`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| soft_rst | input | 1 | Controller soft reset command |
| in_valid | input | 1 | A complete frame is offered this cycle |
| in_id | input | 29 | Frame identifier |
| in_ext | input | 1 | Extended identifier format flag |
| in_dlc | input | 4 | Length code |
| in_data | input | 64 | Payload, byte k in bits 8k+7:8k |
| flt_accept | input | 1 | Acceptance filter verdict for the offered frame |
| flt_group | input | 5 | Index of the matching filter group |
| cmd_release | input | 1 | Free the oldest held frame |
| cmd_clr_ovr | input | 1 | Clear the overrun flag |
| rx_irq_en | input | 1 | Receive interrupt enable |
| ovr_irq_en | input | 1 | Overrun interrupt enable |
| rd_valid | output | 1 | At least one frame is held |
| rd_count | output | 2 | Number of held frames |
| rd_id | output | 29 | Identifier of the oldest frame |
| rd_ext | output | 1 | Format flag of the oldest frame |
| rd_dlc | output | 4 | Length code of the oldest frame |
| rd_data | output | 64 | Trimmed payload of the oldest frame |
| rd_group | output | 5 | Filter group index of the oldest frame |
| ovr_status | output | 1 | Sticky data overrun flag |
| rx_irq | output | 1 | Receive interrupt pulse |
| ovr_irq | output | 1 | Overrun interrupt |

## Verification
Several properties are checked on every cycle by the assertions:
- the occupancy bound;
- that an accepted frame at full occupancy raises the overrun flag and leaves occupancy at two;
- the single-step decrement on release;
- that a rejected frame leaves occupancy and the overrun flag unchanged;
- the clearing effect of a soft reset;
- that a receive pulse only appears with data present.

Other behaviours can only be shown by the bench's scenarios against its queue model:
- that the held frames and their group indices really survive an overrun or a rejected frame bit for bit;
- the ordering after a release that coincides with a store;
- the payload trimming for each length code;
- the priority between clearing and setting the overrun flag.

// File: rtl/can_rxb_pkg.sv
package can_rxb_pkg;

    localparam int ID_W   = 29;
    localparam int DLC_W  = 4;
    localparam int NBYTES = 8;
    localparam int DATA_W = NBYTES * 8;
    localparam int GRP_W  = 5;

    typedef struct packed {
        logic [ID_W-1:0]   id;
        logic              ext;
        logic [DLC_W-1:0]  dlc;
        logic [DATA_W-1:0] data;
        logic [GRP_W-1:0]  grp;
    } rx_frame_t;

    // Zero every payload byte at or beyond the effective byte count.
    function automatic logic [DATA_W-1:0] trim_payload(
        input logic [DLC_W-1:0]  dlc,
        input logic [DATA_W-1:0] raw
    );
        logic [DATA_W-1:0] res;
        int unsigned       nb;
        nb  = (int'(dlc) > NBYTES) ? NBYTES : int'(dlc);
        res = raw;
        for (int b = 0; b < NBYTES; b++) begin
            if (b >= int'(nb)) begin
                res[b*8 +: 8] = 8'h00;
            end
        end
        return res;
    endfunction

endpackage

// File: rtl/rxb_slots.sv
module rxb_slots
    import can_rxb_pkg::*;
#(
    parameter int DEPTH = 2,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             shift,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_idx,
    input  rx_frame_t        wr_frame,
    output rx_frame_t        head
);

    rx_frame_t slot_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        rx_frame_t upper;
        if (i == DEPTH - 1) begin : g_last
            assign upper = slot_q[i];
        end else begin : g_mid
            assign upper = slot_q[i+1];
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                slot_q[i] <= '0;
            end else if (wr_en && wr_idx == CNT_W'(i)) begin
                slot_q[i] <= wr_frame;
            end else if (shift) begin
                slot_q[i] <= upper;
            end
        end
    end

    assign head = slot_q[0];

endmodule

// File: rtl/rxb_ctrl.sv
module rxb_ctrl #(
    parameter int DEPTH = 2,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             soft_rst,
    input  logic             accept,
    input  logic             release_req,
    input  logic             clr_ovr,
    input  logic             rx_irq_en,
    output logic [CNT_W-1:0] count,
    output logic             shift,
    output logic             store,
    output logic [CNT_W-1:0] wr_idx,
    output logic             ovr_flag,
    output logic             rx_pulse
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] after_rel;
    logic             ovr_evt;
    logic             ovr_q;
    logic             rxp_q;

    always_comb begin
        shift     = release_req && (cnt_q != '0) && !soft_rst;
        after_rel = cnt_q - CNT_W'(shift);
        store     = accept && !soft_rst && (after_rel < CNT_W'(DEPTH));
        ovr_evt   = accept && !soft_rst && (after_rel == CNT_W'(DEPTH));
        wr_idx    = after_rel;
    end

    always_ff @(posedge clk) begin
        if (rst || soft_rst) begin
            cnt_q <= '0;
            ovr_q <= 1'b0;
            rxp_q <= 1'b0;
        end else begin
            cnt_q <= after_rel + CNT_W'(store);
            rxp_q <= rx_irq_en && store && (cnt_q == '0);
            if (ovr_evt) begin
                ovr_q <= 1'b1;
            end else if (clr_ovr) begin
                ovr_q <= 1'b0;
            end
        end
    end

    assign count    = cnt_q;
    assign ovr_flag = ovr_q;
    assign rx_pulse = rxp_q;

    p_cnt_bound_r1: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_W'(DEPTH));

    p_release_step_r2: assert property (@(posedge clk) disable iff (rst)
        release_req && !accept && !soft_rst && cnt_q != '0
        |=> cnt_q == $past(cnt_q) - CNT_W'(1));

    p_full_overrun_r3: assert property (@(posedge clk) disable iff (rst)
        accept && !release_req && !soft_rst && cnt_q == CNT_W'(DEPTH)
        |=> ovr_q && cnt_q == CNT_W'(DEPTH));

    p_clear_ovr_r8: assert property (@(posedge clk) disable iff (rst)
        clr_ovr && !soft_rst && !(accept && !release_req && cnt_q == CNT_W'(DEPTH))
        |=> !ovr_q);

    p_soft_reset_r10: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> cnt_q == '0 && !ovr_q && !rxp_q);

endmodule

// File: rtl/can_rx_dbuf.sv
module can_rx_dbuf
    import can_rxb_pkg::*;
#(
    parameter int DEPTH = 2,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              soft_rst,
    input  logic              in_valid,
    input  logic [ID_W-1:0]   in_id,
    input  logic              in_ext,
    input  logic [DLC_W-1:0]  in_dlc,
    input  logic [DATA_W-1:0] in_data,
    input  logic              flt_accept,
    input  logic [GRP_W-1:0]  flt_group,
    input  logic              cmd_release,
    input  logic              cmd_clr_ovr,
    input  logic              rx_irq_en,
    input  logic              ovr_irq_en,
    output logic              rd_valid,
    output logic [CNT_W-1:0]  rd_count,
    output logic [ID_W-1:0]   rd_id,
    output logic              rd_ext,
    output logic [DLC_W-1:0]  rd_dlc,
    output logic [DATA_W-1:0] rd_data,
    output logic [GRP_W-1:0]  rd_group,
    output logic              ovr_status,
    output logic              rx_irq,
    output logic              ovr_irq
);

    rx_frame_t        inc;
    rx_frame_t        head;
    logic             accept;
    logic             shift;
    logic             store;
    logic [CNT_W-1:0] wr_idx;
    logic [CNT_W-1:0] count;

    always_comb begin
        accept   = in_valid && flt_accept;
        inc.id   = in_id;
        inc.ext  = in_ext;
        inc.dlc  = in_dlc;
        inc.data = trim_payload(in_dlc, in_data);
        inc.grp  = flt_group;
    end

    rxb_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .soft_rst    (soft_rst),
        .accept      (accept),
        .release_req (cmd_release),
        .clr_ovr     (cmd_clr_ovr),
        .rx_irq_en   (rx_irq_en),
        .count       (count),
        .shift       (shift),
        .store       (store),
        .wr_idx      (wr_idx),
        .ovr_flag    (ovr_status),
        .rx_pulse    (rx_irq)
    );

    rxb_slots #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_slots (
        .clk      (clk),
        .rst      (rst),
        .shift    (shift),
        .wr_en    (store),
        .wr_idx   (wr_idx),
        .wr_frame (inc),
        .head     (head)
    );

    assign rd_count = count;
    assign rd_valid = (count != '0);
    assign rd_id    = head.id;
    assign rd_ext   = head.ext;
    assign rd_dlc   = head.dlc;
    assign rd_data  = head.data;
    assign rd_group = head.grp;
    assign ovr_irq  = ovr_status && ovr_irq_en;

    p_reject_inert_r4: assert property (@(posedge clk) disable iff (rst)
        in_valid && !flt_accept && !cmd_release && !cmd_clr_ovr && !soft_rst
        |=> $stable(rd_count) && $stable(ovr_status) && $stable(rd_id) && $stable(rd_group));

    p_full_head_kept_r3: assert property (@(posedge clk) disable iff (rst)
        accept && !cmd_release && !soft_rst && rd_count == CNT_W'(DEPTH)
        |=> $stable(rd_id) && $stable(rd_data) && $stable(rd_group));

    p_rx_pulse_data_r9: assert property (@(posedge clk) disable iff (rst)
        rx_irq |-> rd_valid && !$past(rd_valid));

endmodule

// File: tb/can_rx_dbuf_test.sv
module can_rx_dbuf_test;
    import can_rxb_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              soft_rst = 1'b0;
    logic              in_valid = 1'b0;
    logic [ID_W-1:0]   in_id = '0;
    logic              in_ext = 1'b0;
    logic [DLC_W-1:0]  in_dlc = '0;
    logic [DATA_W-1:0] in_data = '0;
    logic              flt_accept = 1'b0;
    logic [GRP_W-1:0]  flt_group = '0;
    logic              cmd_release = 1'b0;
    logic              cmd_clr_ovr = 1'b0;
    logic              rx_irq_en = 1'b1;
    logic              ovr_irq_en = 1'b1;
    logic              rd_valid;
    logic [1:0]        rd_count;
    logic [ID_W-1:0]   rd_id;
    logic              rd_ext;
    logic [DLC_W-1:0]  rd_dlc;
    logic [DATA_W-1:0] rd_data;
    logic [GRP_W-1:0]  rd_group;
    logic              ovr_status;
    logic              rx_irq;
    logic              ovr_irq;

    always #4 clk = ~clk;

    can_rx_dbuf uut (
        .clk(clk), .rst(rst), .soft_rst(soft_rst), .in_valid(in_valid),
        .in_id(in_id), .in_ext(in_ext), .in_dlc(in_dlc), .in_data(in_data),
        .flt_accept(flt_accept), .flt_group(flt_group),
        .cmd_release(cmd_release), .cmd_clr_ovr(cmd_clr_ovr),
        .rx_irq_en(rx_irq_en), .ovr_irq_en(ovr_irq_en),
        .rd_valid(rd_valid), .rd_count(rd_count), .rd_id(rd_id),
        .rd_ext(rd_ext), .rd_dlc(rd_dlc), .rd_data(rd_data),
        .rd_group(rd_group), .ovr_status(ovr_status), .rx_irq(rx_irq),
        .ovr_irq(ovr_irq)
    );

    typedef struct {
        logic [ID_W-1:0]   id;
        logic              ext;
        logic [DLC_W-1:0]  dlc;
        logic [DATA_W-1:0] data;
        logic [GRP_W-1:0]  grp;
    } ref_msg_t;

    ref_msg_t m_q[$];
    bit       m_ovr = 0;
    bit       m_rxp = 0;
    int       n_vec = 0;
    int       n_bad = 0;
    bit       done  = 0;
    string    tag   = "R12";

    function automatic logic [DATA_W-1:0] keep_bytes(input logic [DLC_W-1:0] d,
                                                      input logic [DATA_W-1:0] v);
        logic [DATA_W-1:0] r = '0;
        int lim = (d > 8) ? 8 : int'(d);
        for (int k = 0; k < lim; k++) r[8*k +: 8] = v[8*k +: 8];
        return r;
    endfunction

    task automatic model_step();
        bit was_empty;
        bit oev = 0;
        if (rst || soft_rst) begin
            m_q.delete();
            m_ovr = 0;
            m_rxp = 0;
            return;
        end
        was_empty = (m_q.size() == 0);
        if (cmd_release && m_q.size() > 0) void'(m_q.pop_front());
        if (in_valid && flt_accept) begin
            if (m_q.size() < 2) begin
                ref_msg_t e;
                e.id = in_id; e.ext = in_ext; e.dlc = in_dlc;
                e.data = keep_bytes(in_dlc, in_data); e.grp = flt_group;
                m_q.push_back(e);
                m_rxp = rx_irq_en && was_empty;
            end else begin
                oev = 1;
                m_rxp = 0;
            end
        end else begin
            m_rxp = 0;
        end
        if (oev) m_ovr = 1;
        else if (cmd_clr_ovr) m_ovr = 0;
    endtask

    task automatic chk(string what, logic [63:0] act, logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic compare();
        chk("rd_count (R1)", 64'(rd_count), 64'(m_q.size()));
        chk("rd_valid (R1)", 64'(rd_valid), 64'(m_q.size() != 0));
        chk("ovr_status (R3)", 64'(ovr_status), 64'(m_ovr));
        chk("ovr_irq (R7)", 64'(ovr_irq), 64'(m_ovr && ovr_irq_en));
        chk("rx_irq (R9)", 64'(rx_irq), 64'(m_rxp));
        if (m_q.size() > 0) begin
            chk("rd_id (R1)", 64'(rd_id), 64'(m_q[0].id));
            chk("rd_ext (R1)", 64'(rd_ext), 64'(m_q[0].ext));
            chk("rd_dlc (R11)", 64'(rd_dlc), 64'(m_q[0].dlc));
            chk("rd_data (R11)", rd_data, m_q[0].data);
            chk("rd_group (R5)", 64'(rd_group), 64'(m_q[0].grp));
        end
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare();
        in_valid = 0; cmd_release = 0; cmd_clr_ovr = 0; soft_rst = 0;
    endtask

    task automatic offer(int k, bit acc);
        in_valid   = 1;
        flt_accept = acc;
        in_id      = ID_W'(32'h0ABC_0000 + k * 97);
        in_ext     = k[0];
        in_dlc     = DLC_W'(k % 16);
        in_data    = {8{k[7:0]}} ^ 64'hF1E2_D3C4_B5A6_9788;
        flt_group  = GRP_W'(k * 7);
    endtask

    initial begin
        repeat (3) tick();
        rst = 0;
        tag = "R12"; tick();

        tag = "R1";  offer(1, 1); tick(); offer(2, 1); tick(); tick();
        tag = "R2";  cmd_release = 1; tick(); cmd_release = 1; tick();
        cmd_release = 1; tick();
        tag = "R3";  offer(3, 1); tick(); offer(4, 1); tick(); offer(5, 1); tick();
        ovr_irq_en = 0; tick(); ovr_irq_en = 1;
        tag = "R8";  cmd_clr_ovr = 1; tick();
        offer(6, 1); cmd_clr_ovr = 1; tick(); tick();
        cmd_clr_ovr = 1; tick();
        tag = "R4";  offer(7, 0); tick(); offer(8, 0); tick();
        cmd_release = 1; tick(); offer(9, 0); tick(); offer(10, 1); tick();
        tag = "R6";  offer(11, 1); cmd_release = 1; tick(); tick();
        cmd_release = 1; tick();
        tag = "R10"; offer(12, 1); soft_rst = 1; cmd_release = 1; tick();
        offer(13, 1); tick(); offer(14, 1); tick(); offer(15, 1); tick();
        soft_rst = 1; cmd_clr_ovr = 1; tick(); tick();
        tag = "R11";
        for (int d = 0; d < 16; d++) begin
            offer(16 + d, 1); in_dlc = DLC_W'(d); tick();
            cmd_release = 1; tick();
        end
        tag = "R9";  rx_irq_en = 0; offer(40, 1); tick(); cmd_release = 1; tick();
        rx_irq_en = 1; offer(41, 1); tick(); offer(42, 1); tick();
        soft_rst = 1; tick();
        tag = "R5 mix";
        begin
            logic [15:0] lf = 16'hACE1;
            for (int c = 0; c < 600; c++) begin
                lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
                if (lf[0]) offer(100 + c, lf[1] | lf[2]);
                cmd_release = lf[3] & lf[4];
                cmd_clr_ovr = (lf[7:5] == 3'b101);
                soft_rst    = (lf[15:10] == 6'h3F);
                rx_irq_en   = lf[8] | lf[9];
                ovr_irq_en  = lf[11] | lf[12];
                tick();
            end
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog %s: actual hung expected finished", tag);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule